// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM with late write

This block models a synchronous static RAM whose data bus never needs an idle cycle when traffic switches between reads and writes. Address, control and byte-lane write enables are taken at a rising clock edge. The write data for a command arrives a fixed number of edges later: one edge in flow-through mode and two edges in pipelined mode. This data delay matches the read data delay, so the shared bus stays busy on every cycle.

A load command starts a new access from the address pins. Advance commands then step through a four-beat burst from that starting point, in either linear or interleaved order. The bidirectional bus is split into `din`, `dout` and a drive enable `dq_oe`. A clock enable freezes the whole block. An asynchronous output enable and an asynchronous sleep input can silence the drivers at any moment. A read that targets a word whose late write has not yet landed returns the pending data, lane by lane.

Top module: `nbt_sram`

## Requirements
- R1: In pipelined mode (`pipe_mode`=1), read data is driven in the cycle that follows the second enabled edge counted from the read command. In flow-through mode (`pipe_mode`=0), it is driven in the cycle that follows the command edge itself. `dq_oe` is high exactly while read data is presented.
- R2: In pipelined mode, the write data of a write command is taken from `din` at the second enabled edge after the command. In flow-through mode, it is taken at the first enabled edge after the command.
- R3: Reads and writes may follow each other in any order on consecutive enabled edges with no idle cycle, and every access completes.
- R4: `lane_we` is captured with each write command. Bit k set writes `din[9k+8:9k]`, and bit k clear leaves that lane unchanged. Every combination is valid, including all four lanes or none.
- R5: A load command (`adv`=0) starts an access only when `cs` is 3'b111. With any bit of `cs` low it is a deselect: no access is started, no data is driven and any burst in progress ends.
- R6: A load sets beat 0 at the address pins. Each advance moves to the next beat. With `burst_ilv`=0 the two low address bits are the start value plus the beat, modulo 4. With `burst_ilv`=1 they are the start value XOR the beat. The upper bits do not change, and the beat returns to 0 after beat 3.
- R7: An advance (`adv`=1) keeps the direction of the most recent load and ignores `wr` and `cs`. An advance when no burst is active does nothing.
- R8: While `clk_en` is low, no state changes: no access, no array write, no change of `dout` or of the pipeline.
- R9: `oe` low or `sleep` high forces `dq_oe` low immediately. An enabled edge with `sleep` high starts no access and ends any active burst, while writes already in flight still complete.
- R10: In pipelined mode, a read of the word whose write data arrives at the edge where the read is output-registered returns that incoming data in the enabled lanes and the array contents in the other lanes.
- R11: After a synchronous reset (`rst_n` low at a clock edge), no access is pending, no burst is active and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; low holds all state |
| adv | input | 1 | 1 = advance the burst, 0 = load a new address |
| wr | input | 1 | Direction on load: 1 write, 0 read |
| lane_we | input | LANES (4) | Per-lane write enable, sampled with the command |
| cs | input | 3 | Chip selects, all must be high to select |
| addr | input | ADDR_W (8) | Word address |
| pipe_mode | input | 1 | 1 pipelined, 0 flow-through; change only under reset |
| burst_ilv | input | 1 | 0 linear, 1 interleaved burst order |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep; blocks accesses and drivers |
| din | input | LANES*LANE_W (36) | Write data side of the bus |
| dout | output | LANES*LANE_W (36) | Read data side of the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Some rules are checked by the assertions on every cycle. These are the immediate driver shutdown by `oe` or `sleep`, the silence after a deselected load, the presence of output after a selected read, a frozen `dout` while the clock enable is low, the inert advance with no burst active, and the quiet state after reset. Only the bench scenarios can show the data rules. They cover the late-write data edge in each mode, lane merging and forwarding on read-after-write, the linear and interleaved beat order with its wrap, and direction inheritance on advance. The bench checks these against a behavioural model that keeps the memory and a queue of pending writes.

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en,
  input  logic                     adv,
  input  logic                     wr,
  input  logic [LANES-1:0]         lane_we,
  input  logic [2:0]               cs,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     pipe_mode,
  input  logic                     burst_ilv,
  input  logic                     oe,
  input  logic                     sleep,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dq_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              act, bdir;
  logic [ADDR_W-1:0] base;
  logic [1:0]        beat, nbeat, lo;
  logic              c_v, c_w;
  logic [ADDR_W-1:0] c_a;
  logic              s1_v, s1_w, s2_v, s2_w, q_v;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_be, s2_be;
  logic              w_v;
  logic [ADDR_W-1:0] w_a;
  logic [LANES-1:0]  w_be;
  logic              a_match;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_raw, rd_fwd, q;

  // burst sequencing
  assign nbeat = beat + 2'd1;
  assign lo    = burst_ilv ? (base[1:0] ^ nbeat) : (base[1:0] + nbeat);
  assign c_v   = clk_en & ~sleep & (adv ? act : &cs);
  assign c_w   = adv ? bdir : wr;
  assign c_a   = adv ? {base[ADDR_W-1:2], lo} : addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      bdir <= 1'b0;
      base <= '0;
      beat <= '0;
    end else if (clk_en) begin
      if (sleep) begin
        act <= 1'b0;
      end else if (!adv) begin
        act <= &cs;
        if (&cs) begin
          base <= addr;
          bdir <= wr;
          beat <= 2'd0;
        end
      end else if (act) begin
        beat <= nbeat;
      end
    end
  end

  // command pipeline
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      q_v  <= 1'b0;
    end else if (clk_en) begin
      s1_v <= c_v;
      s2_v <= s1_v;
      q_v  <= s1_v & ~s1_w;
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en) begin
      s1_w  <= c_w;
      s1_a  <= c_a;
      s1_be <= lane_we;
      s2_w  <= s1_w;
      s2_a  <= s1_a;
      s2_be <= s1_be;
    end
  end

  // late write: data edge is one or two enabled edges after the command
  assign w_v  = pipe_mode ? (s2_v & s2_w) : (s1_v & s1_w);
  assign w_a  = pipe_mode ? s2_a  : s1_a;
  assign w_be = pipe_mode ? s2_be : s1_be;

  always_ff @(posedge clk) begin
    if (rst_n && clk_en && w_v) begin
      for (int i = 0; i < LANES; i++) begin
        if (w_be[i]) mem[w_a][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
      end
    end
  end

  // read path with forwarding of the write landing this edge
  assign rd_raw  = mem[s1_a];
  assign a_match = pipe_mode & s2_v & s2_w & (s2_a == s1_a);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_fwd[g*LANE_W +: LANE_W] = (a_match & s2_be[g]) ? din[g*LANE_W +: LANE_W]
                                                             : rd_raw[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (clk_en) q <= rd_fwd;
  end

  assign dout  = pipe_mode ? q : rd_raw;
  assign dq_oe = (pipe_mode ? q_v : (s1_v & ~s1_w)) & oe & ~sleep;

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              adv,
  input logic              wr,
  input logic [2:0]        cs,
  input logic              pipe_mode,
  input logic              oe,
  input logic              sleep,
  input logic [DATA_W-1:0] dout,
  input logic              dq_oe,
  input logic              act,
  input logic              s1_v
);
  assert_drv_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe || sleep) |-> !dq_oe);

  assert_desel_pipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && !adv && !(&cs) && pipe_mode) ##1 clk_en |=> !dq_oe);

  assert_desel_flow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && !adv && !(&cs) && !pipe_mode) |=> !dq_oe);

  assert_rd_flow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && !adv && (&cs) && !wr && !pipe_mode) |=> (dq_oe || !oe || sleep));

  assert_rd_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && !adv && (&cs) && !wr && pipe_mode) ##1 clk_en |=> (dq_oe || !oe || sleep));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && dq_oe) |=> $stable(dout));

  assert_idle_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && adv && !act) |=> !s1_v);

  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dq_oe);
endmodule

bind nbt_sram nbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv(adv), .wr(wr), .cs(cs),
  .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep), .dout(dout), .dq_oe(dq_oe),
  .act(act), .s1_v(s1_v)
);

// File: tb/nbt_sram_tb.sv
module nbt_sram_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1, adv = 1'b0, wr = 1'b0;
  logic [3:0]  lane_we = 4'h0;
  logic [2:0]  cs = 3'b000;
  logic [7:0]  addr = 8'h0;
  logic        pipe_mode = 1'b1, burst_ilv = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dq_oe;

  int checks = 0, errors = 0, sc = 0;
  string tag = "R11";
  bit finished = 0;

  always #5 clk = ~clk;

  nbt_sram u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv(adv), .wr(wr), .lane_we(lane_we),
    .cs(cs), .addr(addr), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv), .oe(oe),
    .sleep(sleep), .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  // behavioural reference model
  typedef struct { int due; int a; logic [3:0] be; } pw_t;
  pw_t         pq[$];
  logic [35:0] mm [256];
  int          e = 0, m_base = 0, m_beat = 0, rd_a = 0, fa = 0;
  bit          m_act = 0, m_dir = 0, rd_prev = 0, qv = 0, fv = 0;
  logic [35:0] qd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pq.delete(); m_act = 0; rd_prev = 0; qv = 0; fv = 0; m_beat = 0;
    end else if (clk_en) begin
      bit issue, iw; int ia, lo;
      e++;
      for (int i = pq.size() - 1; i >= 0; i--) begin
        if (pq[i].due == e) begin
          for (int k = 0; k < 4; k++)
            if (pq[i].be[k]) mm[pq[i].a][k*9 +: 9] = din[k*9 +: 9];
          pq.delete(i);
        end
      end
      if (pipe_mode) begin
        qv = rd_prev;
        if (rd_prev) qd = mm[rd_a];
      end
      issue = 0; ia = 0;
      if (sleep) m_act = 0;
      else if (!adv) begin
        if (cs == 3'b111) begin
          m_act = 1; m_dir = wr; m_base = addr; m_beat = 0; issue = 1; ia = addr;
        end else m_act = 0;
      end else if (m_act) begin
        m_beat = (m_beat + 1) % 4;
        lo = burst_ilv ? ((m_base % 4) ^ m_beat) : ((m_base + m_beat) % 4);
        ia = (m_base / 4) * 4 + lo;
        issue = 1;
      end
      iw = m_dir;
      rd_prev = issue && !iw;
      rd_a = ia;
      if (issue && iw) pq.push_back('{e + (pipe_mode ? 2 : 1), ia, lane_we});
      fv = issue && !iw;
      fa = ia;
    end
  end

  task automatic cmp();
    logic        eo;
    logic [35:0] ed;
    eo = (pipe_mode ? qv : fv) & oe & !sleep;
    ed = pipe_mode ? qd : mm[fa];
    checks++;
    if (dq_oe !== eo) begin
      errors++;
      $display("FAIL %s dq_oe actual %b expected %b at %0t", tag, dq_oe, eo, $time);
    end else if (eo && dout !== ed) begin
      errors++;
      $display("FAIL %s dout actual %h expected %h at %0t", tag, dout, ed, $time);
    end
  endtask

  task automatic cmd(bit ce, bit a_adv, bit w, logic [3:0] be, logic [2:0] c, logic [7:0] a);
    @(negedge clk);
    cmp();
    clk_en = ce; adv = a_adv; wr = w; lane_we = be; cs = c; addr = a;
    sc++;
    din = 36'(sc * 36'h9E3779B9 + 36'h123456789);
  endtask

  task automatic ld(bit w, logic [7:0] a, logic [3:0] be); cmd(1, 0, w, be, 3'b111, a); endtask
  task automatic nx(); cmd(1, 1, 0, 4'hF, 3'b111, 8'h0); endtask
  task automatic nop(int n); for (int i = 0; i < n; i++) cmd(1, 0, 0, 4'h0, 3'b000, 8'h0); endtask

  task automatic do_reset(bit pm);
    @(negedge clk);
    rst_n = 0; pipe_mode = pm; clk_en = 1; adv = 0; cs = 3'b000; oe = 1; sleep = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (dq_oe !== 1'b0) begin
      errors++;
      $display("FAIL R11 dq_oe actual %b expected 0 in reset", dq_oe);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (dq_oe !== 1'b0) begin
      errors++;
      $display("FAIL R11 dq_oe actual %b expected 0 after reset", dq_oe);
    end
  endtask

  task automatic suite();
    tag = "R2"; burst_ilv = 0;
    for (int i = 0; i < 8; i++) ld(1, 8'h10 + 8'(i), 4'hF);
    tag = "R6 linear write";
    ld(1, 8'h22, 4'hF); nx(); nx(); nx();
    tag = "R6 interleaved write"; burst_ilv = 1;
    ld(1, 8'h31, 4'hF); nx(); nx(); nx();
    burst_ilv = 0; nop(3);
    tag = "R1"; ld(0, 8'h10, 4'h0); nop(3);
    for (int i = 0; i < 4; i++) ld(0, 8'h30 + 8'(i), 4'h0);
    nop(3);
    tag = "R3 R10";
    ld(1, 8'h14, 4'hF); ld(0, 8'h11, 4'h0); ld(1, 8'h15, 4'hF); ld(0, 8'h14, 4'h0);
    ld(0, 8'h15, 4'h0);
    tag = "R4 R10";
    ld(1, 8'h10, 4'b0101); ld(0, 8'h10, 4'h0); ld(1, 8'h11, 4'h0); ld(0, 8'h11, 4'h0);
    ld(1, 8'h12, 4'b1010); nop(1); ld(0, 8'h12, 4'h0); nop(3);
    tag = "R6 interleaved read wrap"; burst_ilv = 1;
    ld(0, 8'h21, 4'h0); nx(); nx(); nx(); nx();
    tag = "R6 linear read"; burst_ilv = 0;
    ld(0, 8'h23, 4'h0); nx(); nx(); nx(); nx(); nop(3);
    tag = "R5";
    for (int k = 0; k < 3; k++) begin
      cmd(1, 0, 0, 4'h0, 3'b111 ^ (3'b001 << k), 8'h10);
      nop(2);
    end
    tag = "R7";
    nx(); nx(); nop(2);
    ld(0, 8'h12, 4'h0); cmd(1, 1, 1, 4'hF, 3'b000, 8'h55); nop(3);
    ld(1, 8'h17, 4'hF); cmd(1, 1, 0, 4'h3, 3'b000, 8'h00); nop(2);
    ld(0, 8'h17, 4'h0); ld(0, 8'h14, 4'h0); nop(3);
    tag = "R8";
    ld(0, 8'h13, 4'h0); ld(0, 8'h15, 4'h0);
    for (int i = 0; i < 3; i++) cmd(0, 0, 1, 4'hF, 3'b111, 8'h13);
    nop(3);
    ld(1, 8'h16, 4'hF); cmd(0, 0, 0, 4'h0, 3'b111, 8'h16); cmd(0, 1, 0, 4'h0, 3'b111, 8'h0);
    nop(2); ld(0, 8'h16, 4'h0); nop(3);
    tag = "R9";
    ld(0, 8'h10, 4'h0); nop(1);
    @(negedge clk); cmp(); oe = 0;
    nop(1); oe = 1; nop(2);
    ld(0, 8'h20, 4'h0); nx();
    @(negedge clk); cmp(); sleep = 1;
    nx(); nx(); sleep = 0; nx(); nx(); nop(3);
    ld(1, 8'h18, 4'hF); @(negedge clk); cmp(); sleep = 1; adv = 0; cs = 3'b000;
    nop(2); sleep = 0; ld(0, 8'h18, 4'h0); nop(3);
  endtask

  initial begin
    do_reset(1);
    suite();
    do_reset(0);
    suite();
    nop(2);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule